// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. The host hands over one read or one write per request. The block turns each request into a timed series of strobes: chip select, output enable and write enable, all active low. It also drives the address bus and the write-data bus, and it enables the write-data driver only while a write is in progress. For a read, it samples the memory's data lines at the end of the access wait and returns the sampled word to the host.

Each timing interval is a parameter counted in clock cycles, and every interval must be at least 1. The intervals are the address setup before the write strobe, the write-pulse width, the data setup, the chip-select-to-write-end time, the address and data hold, the access times from address, from chip select and from output enable, and the output-disable delay. The block folds these into phase lengths. A single shared down-counter times all phases.

The request side is valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that transfer until the last phase of the operation has ended, and the host holds off while it is low. A `req_valid` pulse that arrives while `req_ready` is low has no effect. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse, and the host must take `rsp_rdata` in that cycle.

Top module: `sram_seq`

## Requirements
- R1: While reset is applied and just after it is released, `req_ready`=1, `sram_ce_n`=`sram_oe_n`=`sram_we_n`=1, `sram_wdata_oe`=0 and `rsp_valid`=0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the operation's final phase has ended. While `req_ready` is 0, a `req_valid` pulse changes neither the memory nor the sequence.
- R3: A write (`req_write`=1) first holds `sram_ce_n`=0 and `sram_we_n`=1 for exactly SETUP=T_AS cycles. During that time the address and write data are driven and `sram_wdata_oe`=1. The address stays stable for as long as `sram_ce_n` is 0.
- R4: `sram_we_n` then stays 0 for exactly PULSE = max(T_WP, T_DS, T_CSW−T_AS, 1) cycles.
- R5: After `sram_we_n` rises, `sram_ce_n` stays 0 and the address and data stay driven for exactly HOLD = max(T_AH, T_DH) cycles. After that, `req_ready` returns to 1. The memory stores the word present at the rising edge of the write strobe.
- R6: A read (`req_write`=0) holds `sram_ce_n`=0 and `sram_oe_n`=0 for exactly ACC = max(T_AA, T_ACS, T_OE) cycles. It samples `sram_rdata` at the end of the last of those cycles.
- R7: `rsp_valid` is 1 for exactly one cycle, the cycle after the sample. In that cycle, `rsp_rdata` equals the sampled word and both `sram_ce_n` and `sram_oe_n` are 1.
- R8: After the read access, `req_ready` stays 0 for T_OZ more cycles, with `sram_ce_n`=`sram_oe_n`=1, so the memory's outputs can float before the next operation.
- R9: `sram_wdata_oe` is 1 only during the three write phases, and it is never 1 in a cycle where `sram_oe_n` is 0.
- R10: `sram_we_n` is 0 only in cycles where `sram_ce_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle; a request transfers this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DW | Read data returned to the host |
| sram_addr | output | AW | Memory address bus |
| sram_wdata | output | DW | Memory write-data lines |
| sram_wdata_oe | output | 1 | Enable for the write-data bus driver |
| sram_rdata | input | DW | Memory read-data lines |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
A memory model in the bench presents a garbage word until chip select and output enable have both been low for ACC cycles. A read that samples one cycle early therefore returns the wrong value. The bench measures the setup, pulse, hold, access and release lengths at the pins on every operation, and it commits writes only on the rising edge of the write strobe. The stimulus covers writes of all-zeros, all-ones and alternating bit patterns, reads of untouched locations, and back-to-back write-then-read and read-then-write pairs, which show whether the release gap and the hold gap are honoured. A request raised while the block is busy is then read back to confirm that it did not overwrite the location.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WSET = 3'd1,
    PH_WPUL = 3'd2,
    PH_WHLD = 3'd3,
    PH_RACC = 3'd4,
    PH_RREL = 3'd5
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_write_phase(input phase_t p);
    return (p == PH_WSET) || (p == PH_WPUL) || (p == PH_WHLD);
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // a freshly loaded non-zero count cannot report expiry on the next cycle (R4)
  p_load_no_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CW       = 4,
  parameter int SETUP    = 1,
  parameter int PULSE    = 2,
  parameter int HOLD     = 2,
  parameter int ACC      = 3,
  parameter int REL      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          is_write,
  input  logic          zero,
  output phase_t        phase_q,
  output phase_t        phase_d,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          sample
);
  localparam logic [CW-1:0] L_SETUP = CW'(SETUP - 1);
  localparam logic [CW-1:0] L_PULSE = CW'(PULSE - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(HOLD - 1);
  localparam logic [CW-1:0] L_ACC   = CW'(ACC - 1);
  localparam logic [CW-1:0] L_REL   = CW'(REL - 1);

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    sample   = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        load = 1'b1;
        if (is_write) begin
          phase_d  = PH_WSET;
          load_val = L_SETUP;
        end else begin
          phase_d  = PH_RACC;
          load_val = L_ACC;
        end
      end
      PH_WSET: if (zero) begin
        phase_d  = PH_WPUL;
        load     = 1'b1;
        load_val = L_PULSE;
      end
      PH_WPUL: if (zero) begin
        phase_d  = PH_WHLD;
        load     = 1'b1;
        load_val = L_HOLD;
      end
      PH_WHLD: if (zero) phase_d = PH_IDLE;
      PH_RACC: if (zero) begin
        phase_d  = PH_RREL;
        load     = 1'b1;
        load_val = L_REL;
        sample   = 1'b1;
      end
      PH_RREL: if (zero) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // the write pulse is entered only from the setup phase (R3)
  p_pulse_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WPUL && $past(phase_q) != PH_WPUL) |-> $past(phase_q) == PH_WSET);
  // the release gap is entered only from the read access (R8)
  p_release_after_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RREL && $past(phase_q) != PH_RREL) |-> $past(phase_q) == PH_RACC);
endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          sample,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic [DW-1:0] sram_rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          write_q,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_rdata <= sram_rdata;
    end
  end

  // a response is a single-cycle pulse (R7)
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // returned data does not move while the pulse is shown (R7)
  p_rsp_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsp_valid) |-> $stable(rsp_rdata));
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int T_AS  = 1,
  parameter int T_WP  = 2,
  parameter int T_DS  = 1,
  parameter int T_CSW = 2,
  parameter int T_AH  = 1,
  parameter int T_DH  = 2,
  parameter int T_AA  = 3,
  parameter int T_ACS = 2,
  parameter int T_OE  = 1,
  parameter int T_OZ  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_wdata,
  output logic          sram_wdata_oe,
  input  logic [DW-1:0] sram_rdata,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);
  localparam int SETUP = imax(T_AS, 1);
  localparam int PULSE = imax(imax(T_WP, T_DS), imax(T_CSW - SETUP, 1));
  localparam int HOLD  = imax(imax(T_AH, T_DH), 1);
  localparam int ACC   = imax(imax(T_AA, T_ACS), imax(T_OE, 1));
  localparam int REL   = imax(T_OZ, 1);
  localparam int LMAX  = imax(imax(SETUP, PULSE), imax(imax(HOLD, ACC), REL));
  localparam int CW    = $clog2(LMAX + 1);

  phase_t        phase_q, phase_d;
  logic          accept, zero, load, sample, write_q;
  logic [CW-1:0] load_val;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  sram_seq_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
  );

  sram_seq_ctrl #(
    .CW(CW), .SETUP(SETUP), .PULSE(PULSE), .HOLD(HOLD), .ACC(ACC), .REL(REL)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_write(req_write), .zero(zero),
    .phase_q(phase_q), .phase_d(phase_d), .load(load), .load_val(load_val),
    .sample(sample)
  );

  sram_seq_dpath #(.AW(AW), .DW(DW)) dpath_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sample(sample),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .sram_rdata(sram_rdata), .addr_q(sram_addr), .wdata_q(sram_wdata),
    .write_q(write_q), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // Strobes are registered from the next phase so that each pin changes
  // from a flop, never from a decode of several state bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n     <= 1'b1;
      sram_oe_n     <= 1'b1;
      sram_we_n     <= 1'b1;
      sram_wdata_oe <= 1'b0;
    end else begin
      sram_ce_n     <= !(is_write_phase(phase_d) || phase_d == PH_RACC);
      sram_oe_n     <= (phase_d != PH_RACC);
      sram_we_n     <= (phase_d != PH_WPUL);
      sram_wdata_oe <= is_write_phase(phase_d);
    end
  end

  p_no_bus_fight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_wdata_oe && !sram_oe_n));
  p_we_needs_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_wdata_oe && $past(sram_wdata_oe)) |-> $stable(sram_wdata));
endmodule

// File: tb/sram_seq_tb_top.sv
`timescale 1ns/1ps
module sram_seq_tb_top;
  localparam int AW = 8, DW = 8;
  localparam int SETUP = 1, PULSE = 2, HOLD = 2, ACC = 3, REL = 2;
  localparam logic [7:0] GARBAGE = 8'hEE;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_wdata_oe, sram_ce_n, sram_oe_n, sram_we_n;
  logic [DW-1:0] rsp_rdata, sram_wdata, sram_rdata;
  logic [AW-1:0] sram_addr;

  int total = 0, bad = 0, cycles = 0;
  logic [DW-1:0] model_mem [256];
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] exp_q [$];
  int age = 0;
  logic last_we = 1;

  always #2 clk = ~clk;

  sram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_wdata_oe(sram_wdata_oe), .sram_rdata(sram_rdata),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: data valid only after ACC cycles of chip select and output enable
  always @(posedge clk) begin
    if (!sram_ce_n && !sram_oe_n) age <= age + 1;
    else age <= 0;
  end
  assign sram_rdata = (!sram_ce_n && !sram_oe_n && age >= ACC - 1) ? model_mem[sram_addr] : GARBAGE;

  // writes commit on the rising write strobe (R5)
  always @(negedge clk) begin
    if (last_we == 0 && sram_we_n == 1 && !sram_ce_n) model_mem[sram_addr] = sram_wdata;
    last_we = sram_we_n;
  end

  // pin monitor and scoreboard
  int setup_n = 0, pulse_n = 0, hold_n = 0, acc_n = 0, rel_n = 0, overlap = 0;
  bit holding = 0, releasing = 0;
  always @(negedge clk) if (rst_n) begin
    cycles++;
    if (sram_wdata_oe && !sram_oe_n) overlap++;
    if (!sram_we_n) pulse_n++;
    else if (pulse_n > 0) begin
      chk(pulse_n == PULSE, "R4 pulse width", pulse_n, PULSE);
      chk(setup_n == SETUP, "R3 setup length", setup_n, SETUP);
      pulse_n = 0; setup_n = 0; holding = 1; hold_n = 0;
    end
    if (!sram_ce_n && sram_we_n && sram_wdata_oe && !holding) setup_n++;
    if (holding) begin
      if (!sram_ce_n) hold_n++;
      else begin
        chk(hold_n == HOLD, "R5 hold length", hold_n, HOLD);
        chk(req_ready == 1, "R5 ready after hold", req_ready, 1);
        holding = 0;
      end
    end
    if (!sram_ce_n && !sram_oe_n) acc_n++;
    else if (acc_n > 0) begin
      chk(acc_n == ACC, "R6 access length", acc_n, ACC);
      acc_n = 0; releasing = 1; rel_n = 0;
    end
    if (releasing) begin
      if (!req_ready) rel_n++;
      else begin
        chk(rel_n == REL, "R8 release gap", rel_n, REL);
        releasing = 0;
      end
    end
    if (rsp_valid) begin
      chk(sram_ce_n && sram_oe_n, "R7 strobes idle at response", {sram_ce_n, sram_oe_n}, 3);
      if (exp_q.size() == 0) chk(0, "R7 unexpected response", rsp_rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R6 read data", rsp_rdata, e);
      end
    end
  end

  task automatic do_op(input bit wr, input logic [7:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[a] = d; else exp_q.push_back(shadow[a]);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2 ready low after accept", req_ready, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = 8'(i) ^ 8'h3C;
      shadow[i]    = 8'(i) ^ 8'h3C;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1 && sram_ce_n && sram_oe_n && sram_we_n && !sram_wdata_oe && !rsp_valid,
        "R1 reset outputs", {req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_wdata_oe, rsp_valid}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && sram_ce_n, "R1 idle after reset", {req_ready, sram_ce_n}, 3);
    // writes with distinct patterns, then reads
    do_op(1, 8'h10, 8'h00);
    do_op(1, 8'h11, 8'hFF);
    do_op(1, 8'h12, 8'hA5);
    do_op(1, 8'h13, 8'h5A);
    do_op(0, 8'h10, 8'h00);
    do_op(0, 8'h11, 8'h00);
    do_op(0, 8'h12, 8'h00);
    do_op(0, 8'h13, 8'h00);
    // untouched location
    do_op(0, 8'h80, 8'h00);
    // back-to-back write then read of the same word, read then write
    do_op(1, 8'h20, 8'h77);
    do_op(0, 8'h20, 8'h00);
    do_op(0, 8'h21, 8'h00);
    do_op(1, 8'h21, 8'h81);
    do_op(0, 8'h21, 8'h00);
    // R2: request raised while busy is ignored
    do_op(1, 8'h30, 8'hC3);
    req_valid = 1; req_write = 1; req_addr = 8'h09; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2 still busy", req_ready, 0);
    do_op(0, 8'h09, 8'h00);
    do_op(0, 8'h30, 8'h00);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(overlap == 0, "R9 driver never with output enable", overlap, 0);
    chk(exp_q.size() == 0, "R7 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // R10 pin check: write strobe only under chip select
  always @(negedge clk) if (rst_n && !sram_we_n && sram_ce_n)
    chk(0, "R10 write strobe without select", sram_ce_n, 0);

  initial begin
    #40000;
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule